// File: doc/BRIEF.md
# Bit-Clear and Negative-Branch Execution Unit

This block executes two instruction forms of a small 8-bit-data controller whose instruction words are 16 bits wide. It clears a single bit of a data byte selected through banked or shared-window addressing, and it takes a relative branch when an external negative flag is set. Any other instruction word runs as a one-cycle no-op. The unit keeps its own program counter, a 4-bit bank register and a small byte store.

Every instruction cycle takes four clocks, in the order decode, read, process and write. A caller places an instruction word on `instrWord` at the start of the decode phase and holds it for four clocks. A taken branch loads its target in the write phase. It then spends the whole next instruction cycle as a flush, with `stall` high. Byte store contents can be preloaded through a write port and observed through a read port.

Top module: `bcb_exec_unit`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter and the bank register to 0, puts the phase at decode (0), and drives `stall` low.
- R2: `phase` steps 0 (decode), 1 (read), 2 (process), 3 (write), then back to 0, once per clock. The instruction word and `negFlag` must be held for all four clocks of a cycle.
- R3: A word of the form 1001 bbba ffffffff (bits 15:12 = 1001, bit select b in bits 11:9, a in bit 8, file byte f in bits 7:0) clears bit b of the addressed byte. It leaves the other seven bits unchanged and writes the result back at the end of the write phase.
- R4: With a = 0, the operand address is the 12-bit value {f[7] repeated four times, f}. File bytes 0x00–0x7F therefore map to 0x000–0x07F, and 0x80–0xFF map to 0xF80–0xFFF.
- R5: With a = 1, the operand address is {bank, f}. The bank register is loaded from `bsrIn` on any clock edge where `bsrLoad` is high. The bank value at the end of the read phase is the one used.
- R6: The byte store holds 512 bytes, addressed by the low 9 bits of a 12-bit address. `memWrEn` writes `memWrData` at `memWrAddr` on a clock edge, and `memRdData` shows the byte at `memRdAddr` combinationally.
- R7: A word of the form 1110 0110 nnnnnnnn is a branch, with n a signed 8-bit offset. If `negFlag` is 1 at the edge that ends the write phase, the program counter becomes PC + 2 + 2n (modulo 2^16) at that edge. The counter is always even.
- R8: A branch not taken, a bit-clear and any non-flush instruction advance the program counter by 2 at the edge that ends the write phase. The program counter changes at no other edge.
- R9: After a taken branch, `stall` is high for exactly the next four clocks (one instruction cycle). The word presented during that cycle is ignored: the byte store does not change, and the program counter holds.
- R10: A word that matches neither form leaves the byte store unchanged and behaves as a one-cycle no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instrWord | input | 16 | Instruction word, held for a full instruction cycle |
| negFlag | input | 1 | Negative status flag tested by the branch |
| bsrLoad | input | 1 | Load strobe for the bank register |
| bsrIn | input | 4 | New bank register value |
| memWrEn | input | 1 | Byte store external write enable |
| memWrAddr | input | 12 | Byte store external write address |
| memWrData | input | 8 | Byte store external write data |
| memRdAddr | input | 12 | Byte store observation address |
| memRdData | output | 8 | Byte at memRdAddr |
| pcOut | output | 16 | Program counter (address of the current instruction) |
| phase | output | 2 | Current phase: 0 decode, 1 read, 2 process, 3 write |
| stall | output | 1 | High during the flush cycle after a taken branch |

## Verification
Bit-clears are driven with random bit positions, file bytes and addressing selects, and the bank register is reloaded at random. This separates the shared-window mapping from the banked mapping, and it exposes any clearing of the wrong bit. Directed cases put the same physical byte behind both the upper shared window and bank 15, and make two addresses that differ only above bit 8 alias. Branches are tried with extreme and random offsets in both flag states, which separates the taken and not-taken program counter updates. Bit-clear and near-miss words are issued inside a flush cycle to show that they are discarded. Random non-matching words show that the byte store stays untouched.

// File: rtl/bcb_pkg.sv
package bcb_pkg;

  localparam int FILE_W = 8;

  typedef enum logic [1:0] {
    PH_DECODE  = 2'd0,
    PH_READ    = 2'd1,
    PH_PROCESS = 2'd2,
    PH_WRITE   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    K_NOP  = 2'd0,
    K_BCLR = 2'd1,
    K_BNEG = 2'd2
  } kind_e;

  typedef struct packed {
    logic latchInstr;
    logic readOperand;
    logic clearBit;
    logic writeBack;
    logic pcStep;
    logic pcJump;
  } strobe_t;

  function automatic kind_e decodeWord(input logic [15:0] w);
    kind_e k;
    if (w[15:12] == 4'b1001)      k = K_BCLR;
    else if (w[15:8] == 8'hE6)    k = K_BNEG;
    else                          k = K_NOP;
    return k;
  endfunction

endpackage

// File: rtl/bcb_ctrl.sv
module bcb_ctrl
  import bcb_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  kind_e   instrKind,
  input  logic    negFlag,
  output strobe_t strobes,
  output phase_e  phase,
  output logic    stall
);

  phase_e phaseQ;
  logic   flushQ;
  kind_e  effKind;

  assign effKind = flushQ ? K_NOP : instrKind;

  always_comb begin
    strobes             = '0;
    strobes.latchInstr  = (phaseQ == PH_DECODE);
    strobes.readOperand = (phaseQ == PH_READ)    && (effKind == K_BCLR);
    strobes.clearBit    = (phaseQ == PH_PROCESS) && (effKind == K_BCLR);
    strobes.writeBack   = (phaseQ == PH_WRITE)   && (effKind == K_BCLR);
    strobes.pcJump      = (phaseQ == PH_WRITE)   && (effKind == K_BNEG) && negFlag;
    strobes.pcStep      = (phaseQ == PH_WRITE)   && !flushQ && !strobes.pcJump;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= PH_DECODE;
      flushQ <= 1'b0;
    end else begin
      phaseQ <= phase_e'(phaseQ + 2'd1);
      if (phaseQ == PH_WRITE) flushQ <= strobes.pcJump;
    end
  end

  assign phase = phaseQ;
  assign stall = flushQ;

endmodule

// File: rtl/bcb_datapath.sv
module bcb_datapath
  import bcb_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int BSR_W     = 4,
  parameter int MEM_DEPTH = 512,
  localparam int DADDR_W  = BSR_W + FILE_W,
  localparam int IDX_W    = $clog2(MEM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strobes,
  input  logic [15:0]        instrWord,
  input  logic               bsrLoad,
  input  logic [BSR_W-1:0]   bsrIn,
  input  logic               memWrEn,
  input  logic [DADDR_W-1:0] memWrAddr,
  input  logic [7:0]         memWrData,
  input  logic [DADDR_W-1:0] memRdAddr,
  output logic [7:0]         memRdData,
  output kind_e              instrKind,
  output logic [PC_W-1:0]    pcOut
);

  logic [15:0]        instrQ;
  logic [PC_W-1:0]    pcQ;
  logic [BSR_W-1:0]   bankQ;
  logic [7:0]         dataQ;
  logic [IDX_W-1:0]   opIdxQ;
  logic [7:0]         store [MEM_DEPTH];

  logic [FILE_W-1:0]  fileSel;
  logic               useBank;
  logic [2:0]         bitSel;
  logic [DADDR_W-1:0] opAddr;
  logic [PC_W-1:0]    jumpOff;
  logic               unusedAddrHi;

  assign fileSel = instrQ[7:0];
  assign useBank = instrQ[8];
  assign bitSel  = instrQ[11:9];

  // shared window: low half to bank 0, high half to the top bank
  assign opAddr = useBank ? {bankQ, fileSel} : {{BSR_W{fileSel[FILE_W-1]}}, fileSel};

  assign jumpOff = {{(PC_W-FILE_W-1){fileSel[FILE_W-1]}}, fileSel, 1'b0};

  assign unusedAddrHi = ^{opAddr[DADDR_W-1:IDX_W], memWrAddr[DADDR_W-1:IDX_W],
                          memRdAddr[DADDR_W-1:IDX_W]};

  assign instrKind = decodeWord(instrQ);
  assign memRdData = store[memRdAddr[IDX_W-1:0]];
  assign pcOut     = pcQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      instrQ <= '0;
      pcQ    <= '0;
      bankQ  <= '0;
    end else begin
      if (strobes.latchInstr) instrQ <= instrWord;
      if (bsrLoad)            bankQ  <= bsrIn;
      if (strobes.pcJump)     pcQ    <= pcQ + PC_W'(2) + jumpOff;
      else if (strobes.pcStep) pcQ   <= pcQ + PC_W'(2);
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.readOperand) begin
      dataQ  <= store[opAddr[IDX_W-1:0]];
      opIdxQ <= opAddr[IDX_W-1:0];
    end else if (strobes.clearBit) begin
      dataQ  <= dataQ & ~(8'b1 << bitSel);
    end
  end

  always_ff @(posedge clk) begin
    if (memWrEn)           store[memWrAddr[IDX_W-1:0]] <= memWrData;
    if (strobes.writeBack) store[opIdxQ]               <= dataQ;
  end

endmodule

// File: rtl/bcb_exec_unit.sv
module bcb_exec_unit
  import bcb_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int BSR_W     = 4,
  parameter int MEM_DEPTH = 512,
  localparam int DADDR_W  = BSR_W + FILE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        instrWord,
  input  logic               negFlag,
  input  logic               bsrLoad,
  input  logic [BSR_W-1:0]   bsrIn,
  input  logic               memWrEn,
  input  logic [DADDR_W-1:0] memWrAddr,
  input  logic [7:0]         memWrData,
  input  logic [DADDR_W-1:0] memRdAddr,
  output logic [7:0]         memRdData,
  output logic [PC_W-1:0]    pcOut,
  output logic [1:0]         phase,
  output logic               stall
);

  strobe_t strobes;
  kind_e   instrKind;
  phase_e  phaseCur;

  bcb_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .instrKind (instrKind),
    .negFlag   (negFlag),
    .strobes   (strobes),
    .phase     (phaseCur),
    .stall     (stall)
  );

  bcb_datapath #(
    .PC_W      (PC_W),
    .BSR_W     (BSR_W),
    .MEM_DEPTH (MEM_DEPTH)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .instrWord (instrWord),
    .bsrLoad   (bsrLoad),
    .bsrIn     (bsrIn),
    .memWrEn   (memWrEn),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData),
    .memRdAddr (memRdAddr),
    .memRdData (memRdData),
    .instrKind (instrKind),
    .pcOut     (pcOut)
  );

  assign phase = phaseCur;

endmodule

// File: rtl/bcb_exec_checker.sv
module bcb_exec_checker #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      phase,
  input logic            stall,
  input logic [PC_W-1:0] pcOut
);

  p_phase_order_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase == 2'($past(phase) + 2'd1)));

  p_pc_even_r7: assert property (@(posedge clk) disable iff (rst)
    pcOut[0] == 1'b0);

  p_pc_write_only_r8: assert property (@(posedge clk) disable iff (rst)
    (phase != 2'd3) |=> $stable(pcOut));

  p_stall_start_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(stall) |-> (phase == 2'd0));

  p_stall_steady_r9: assert property (@(posedge clk) disable iff (rst)
    (phase != 2'd0) |-> $stable(stall));

  p_flush_end_r9: assert property (@(posedge clk) disable iff (rst)
    (stall && phase == 2'd3) |=> ($stable(pcOut) && !stall));

endmodule

bind bcb_exec_unit bcb_exec_checker #(.PC_W(PC_W)) chk_i (
  .clk   (clk),
  .rst   (rst),
  .phase (phase),
  .stall (stall),
  .pcOut (pcOut)
);

// File: tb/bcb_exec_unit_tb_top.sv
`timescale 1ns/1ps
module bcb_exec_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] instrWord;
  logic        negFlag;
  logic        bsrLoad;
  logic [3:0]  bsrIn;
  logic        memWrEn;
  logic [11:0] memWrAddr;
  logic [7:0]  memWrData;
  logic [11:0] memRdAddr;
  logic [7:0]  memRdData;
  logic [15:0] pcOut;
  logic [1:0]  phase;
  logic        stall;

  always #2.5 clk = ~clk;

  bcb_exec_unit dut_i (
    .clk(clk), .rst(rst), .instrWord(instrWord), .negFlag(negFlag),
    .bsrLoad(bsrLoad), .bsrIn(bsrIn), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .pcOut(pcOut), .phase(phase), .stall(stall)
  );

  int total = 0;
  int bad   = 0;
  logic [7:0]  mirror [512];
  logic [15:0] mPc;
  logic [3:0]  mBsr;
  logic        mFlush;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] fullAddr(input logic [15:0] w, input logic [3:0] b);
    return w[8] ? {b, w[7:0]} : {{4{w[7]}}, w[7:0]};
  endfunction

  function automatic logic isClr(input logic [15:0] w);
    return w[15:12] == 4'b1001;
  endfunction

  function automatic logic isBr(input logic [15:0] w);
    return w[15:8] == 8'hE6;
  endfunction

  task automatic memCheck(input string req, input logic [11:0] a);
    memRdAddr = a;
    #0.5;
    check(req, "stored byte", memRdData, mirror[a[8:0]]);
  endtask

  // called at a negedge in decode phase; ends at the next decode phase
  task automatic issue(input logic [15:0] w, input logic neg,
                       input logic ld, input logic [3:0] nb);
    logic [11:0] a;
    logic        wasFlush;
    instrWord = w; negFlag = neg; bsrLoad = ld; bsrIn = nb;
    @(negedge clk);
    bsrLoad = 1'b0;
    repeat (3) @(negedge clk);
    if (ld) mBsr = nb;
    a = fullAddr(w, mBsr);
    wasFlush = mFlush;
    if (wasFlush) begin
      mFlush = 1'b0;
    end else if (isClr(w)) begin
      mirror[a[8:0]][w[11:9]] = 1'b0;
      mPc = mPc + 16'd2;
    end else if (isBr(w) && neg) begin
      mPc = mPc + 16'd2 + {{7{w[7]}}, w[7:0], 1'b0};
      mFlush = 1'b1;
    end else begin
      mPc = mPc + 16'd2;
    end
    check("R2", "phase back at decode", phase, 2'd0);
    if (wasFlush) begin
      check("R9", "pc held in flush", pcOut, mPc);
      check("R9", "stall after flush", stall, 1'b0);
      memCheck("R9", a);
    end else if (isClr(w)) begin
      check("R8", "pc after bit-clear", pcOut, mPc);
      memCheck("R3", a);
    end else if (isBr(w)) begin
      check(neg ? "R7" : "R8", "pc after branch", pcOut, mPc);
      check("R9", "stall after branch", stall, mFlush);
    end else begin
      check("R8", "pc after no-op", pcOut, mPc);
      memCheck("R10", a);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; instrWord = '0; negFlag = 1'b0; bsrLoad = 1'b0; bsrIn = '0;
    memWrEn = 1'b0; memWrAddr = '0; memWrData = '0; memRdAddr = '0;
    mPc = '0; mBsr = '0; mFlush = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 512; i++) begin
      memWrEn   = 1'b1;
      memWrAddr = 12'(i);
      memWrData = 8'($urandom);
      mirror[i] = memWrData;
      @(negedge clk);
    end
    memWrEn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "pc at reset", pcOut, 16'd0);
    check("R1", "phase at reset", phase, 2'd0);
    check("R1", "stall at reset", stall, 1'b0);
    memCheck("R6", 12'h1A5);
    @(negedge clk);
    check("R2", "phase after one clock", phase, 2'd1);
    repeat (3) @(negedge clk);
    mPc = 16'd2;
    check("R8", "pc after zero word", pcOut, 16'd2);

    // R1: banked access uses bank 0 after reset
    mirror[9'h033] = mirror[9'h033] | 8'h20;
    memWrAddr = 12'h033; memWrData = mirror[9'h033]; memWrEn = 1'b1;
    issue(16'h0000, 1'b0, 1'b0, 4'd0);
    memWrEn = 1'b0;
    issue({4'b1001, 3'd5, 1'b1, 8'h33}, 1'b0, 1'b0, 4'd0);
    memCheck("R1", 12'h033);
    check("R3", "bit 5 cleared", memRdData[5], 1'b0);

    // R4: shared window, low and high halves
    issue({4'b1001, 3'd7, 1'b0, 8'h05}, 1'b0, 1'b0, 4'd0);
    memCheck("R4", 12'h005);
    issue({4'b1001, 3'd0, 1'b0, 8'h85}, 1'b0, 1'b0, 4'd0);
    memCheck("R4", 12'hF85);
    // R5: bank 15 reaches the same byte as the upper window
    issue({4'b1001, 3'd1, 1'b1, 8'h85}, 1'b0, 1'b1, 4'hF);
    memCheck("R5", 12'hF85);
    check("R5", "bits 0 and 1 cleared", memRdData[1:0], 2'b00);
    // R6: bank 2 folds onto bank 0 in the 512-byte store
    issue({4'b1001, 3'd3, 1'b1, 8'h10}, 1'b0, 1'b1, 4'd2);
    memCheck("R6", 12'h010);

    // R7: extreme offsets, taken
    issue(16'hE680, 1'b1, 1'b0, 4'd0);
    issue({4'b1001, 3'd2, 1'b0, 8'h44}, 1'b0, 1'b0, 4'd0); // flushed, R9
    issue(16'hE67F, 1'b1, 1'b0, 4'd0);
    issue(16'hE601, 1'b1, 1'b0, 4'd0);                     // flushed branch, R9
    issue(16'hE610, 1'b0, 1'b0, 4'd0);                     // not taken
    issue(16'hE710, 1'b1, 1'b0, 4'd0);                     // near miss, R10
    check("R10", "stall after near miss", stall, 1'b0);
    issue(16'h9F00 ^ 16'h6000, 1'b1, 1'b0, 4'd0);          // 0xFF00, R10

    for (int k = 0; k < 160; k++) begin
      logic [15:0] w;
      int sel;
      sel = $urandom_range(0, 6);
      if (sel < 4) begin
        w = {4'b1001, 3'($urandom), 1'($urandom), 8'($urandom)};
      end else if (sel < 6) begin
        w = {8'hE6, 8'($urandom)};
      end else begin
        w = 16'($urandom);
        if (isClr(w) || isBr(w)) w[15:12] = 4'b0011;
      end
      issue(w, 1'($urandom), ($urandom_range(0, 3) == 0), 4'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule